// File: doc/BRIEF.md
# Acknowledged Output Handshake Port

This block is one output lane of a parallel peripheral port. The CPU writes a byte into an output latch. An active-low buffer-full line then tells the peripheral that a byte is waiting. The peripheral takes the byte and pulses an active-low acknowledge. When that pulse ends, the port can raise an interrupt request so the CPU knows it may send the next byte. A set/reset command gates that interrupt through an enable flag.

The port has two drive modes. In the strobed-output mode the latched byte sits on the pins all the time. In the shared-bus mode the pins are driven only while the acknowledge is held low, which leaves the lines free for inbound traffic at other times. Address decoding and arbitration of the shared bus are handled outside the block.

The CPU write strobe is sampled on the block clock. The acknowledge comes from another clock domain, so it passes through a synchronizer of `ACK_SYNC` stages before any edge is detected.

Top module: `ack_out_port`

## Requirements
- R1: Once reset is released, `per_obf_n` is 1, `intr_req` is 0, the interrupt enable is 0, `pin_data` is all zeros and, in strobed mode, `pin_oe` is 1.
- R2: The clock edge that first samples `cpu_wr_n` high after it was low is the write's rising edge. On that edge the port copies `cpu_wdata` into the latch, and `per_obf_n` reads 0 from then on.
- R3: The clock edge that first samples `cpu_wr_n` low after it was high is the write's falling edge. On that edge `intr_req` clears to 0.
- R4: A falling edge of the synchronized acknowledge returns `per_obf_n` to 1. With the default `ACK_SYNC`=2, this takes effect on the third clock edge after `per_ack_n` goes low.
- R5: A rising edge of the synchronized acknowledge sets `intr_req` when all three hold: the byte was taken (the acknowledge fell while `per_obf_n` was 0), `per_obf_n` is 1, and the enable is 1. With `ACK_SYNC`=2 this is the third clock edge after `per_ack_n` goes high.
- R6: An acknowledge pulse that arrives while `per_obf_n` is already 1 never sets `intr_req`.
- R7: When `bsr_stb`=1, the enable takes the value of `bsr_bit` on that clock edge. While the enable is 0, no acknowledge sets `intr_req`.
- R8: With `bidir_mode`=0 (strobed mode), `pin_oe` is 1 at all times and `pin_data` shows the latched byte.
- R9: With `bidir_mode`=1 (shared-bus mode), `pin_oe` is 1 exactly while the synchronized acknowledge is low.
- R10: A write rising edge and an acknowledge falling edge can land on the same clock edge. In that case the write wins: `per_obf_n` stays 0 and the latch takes the new byte.
- R11: If a write falling edge and a qualifying acknowledge rising edge land on the same clock edge, the clear wins and `intr_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_wdata | input | DATA_W | Byte written by the CPU |
| bsr_stb | input | 1 | Set/reset command strobe for the interrupt enable |
| bsr_bit | input | 1 | Value loaded into the enable by the command |
| bidir_mode | input | 1 | 0 = strobed output, 1 = shared-bus output |
| per_ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| per_obf_n | output | 1 | Output buffer full, active low |
| intr_req | output | 1 | Interrupt request to the CPU |
| pin_data | output | DATA_W | Latched byte presented to the pins |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the port with `DATA_W`=4 and the default two-stage acknowledge synchronizer. This shrinks the data space to 16 values, so every value goes through a complete handshake in each of the four combinations of drive mode and interrupt enable. Because the synchronizer depth is fixed, the bench can place a write rising edge and an acknowledge falling edge on the same clock edge, and it can check the interrupt and buffer-full timing down to the exact cycle.

// File: rtl/ack_out_pkg.sv
package ack_out_pkg;

  // A rising edge: the previous sample was low and the current one is high.
  function automatic logic edge_up(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  // A falling edge: the previous sample was high and the current one is low.
  function automatic logic edge_down(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // The interrupt is set only when the peripheral consumed a real byte,
  // nothing is pending any more, and the enable allows it.
  function automatic logic intr_qualify(input logic taken, input logic obf_n,
                                        input logic en);
    return taken & obf_n & en;
  endfunction

  // Output enable for the two drive modes; ack_low is the synchronized level.
  function automatic logic drive_enable(input logic shared_bus, input logic ack_low);
    return shared_bus ? ack_low : 1'b1;
  endfunction

  typedef struct packed {
    logic wr_rise;
    logic wr_fall;
    logic ack_rise;
    logic ack_fall;
  } hs_events_t;

endpackage

// File: rtl/ack_out_sync.sv
module ack_out_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
    end else begin : g_chain
      logic stage_q [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= d_async;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= stage_q[i-1];
          end
        end
      end
      assign q_sync = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ack_out_edge.sv
module ack_out_edge
  import ack_out_pkg::*;
#(
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RESET_VAL;
    else        level_q <= level;
  end

  assign rise = edge_up(level_q, level);
  assign fall = edge_down(level_q, level);

endmodule

// File: rtl/ack_out_ctrl.sv
module ack_out_ctrl
  import ack_out_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hs_events_t ev,
  input  logic       bsr_stb,
  input  logic       bsr_bit,
  output logic       obf_n,
  output logic       taken,
  output logic       ie,
  output logic       intr
);

  // Buffer full: a finished write makes a byte pending; an acknowledge
  // consumes it. A write on the same edge keeps the new byte pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           obf_n <= 1'b1;
    else if (ev.wr_rise)  obf_n <= 1'b0;
    else if (ev.ack_fall) obf_n <= 1'b1;
  end

  // Remember that this acknowledge pulse actually consumed a byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   taken <= 1'b0;
    else if (ev.ack_fall)         taken <= ~obf_n;
    else if (ev.ack_rise)         taken <= 1'b0;
  end

  // Interrupt enable, loaded by the set/reset command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie <= 1'b0;
    else if (bsr_stb) ie <= bsr_bit;
  end

  // Interrupt request: the start of the next write clears it, and that clear
  // takes priority over a set on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      intr <= 1'b0;
    else if (ev.wr_fall)
      intr <= 1'b0;
    else if (ev.ack_rise && intr_qualify(taken, obf_n, ie))
      intr <= 1'b1;
  end

endmodule

// File: rtl/ack_out_drive.sv
module ack_out_drive
  import ack_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shared_bus,
  input  logic              ack_low,
  output logic [DATA_W-1:0] pins,
  output logic              oe
);

  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    latch_q <= '0;
    else if (load) latch_q <= wdata;
  end

  assign pins = latch_q;
  assign oe   = drive_enable(shared_bus, ack_low);

endmodule

// File: rtl/ack_out_port.sv
module ack_out_port
  import ack_out_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ACK_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_n,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              bsr_stb,
  input  logic              bsr_bit,
  input  logic              bidir_mode,
  input  logic              per_ack_n,
  output logic              per_obf_n,
  output logic              intr_req,
  output logic [DATA_W-1:0] pin_data,
  output logic              pin_oe
);

  // Named internal events, visible to the bound checker.
  logic       ack_s;
  logic       wr_rise, wr_fall, ack_rise, ack_fall;
  logic       byte_taken, ie_q;
  hs_events_t ev;

  ack_out_sync #(.STAGES(ACK_SYNC), .RESET_VAL(1'b1)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (per_ack_n),
    .q_sync  (ack_s)
  );

  ack_out_edge #(.RESET_VAL(1'b1)) u_wr_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (cpu_wr_n),
    .rise  (wr_rise),
    .fall  (wr_fall)
  );

  ack_out_edge #(.RESET_VAL(1'b1)) u_ack_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ack_s),
    .rise  (ack_rise),
    .fall  (ack_fall)
  );

  assign ev = '{wr_rise: wr_rise, wr_fall: wr_fall,
                ack_rise: ack_rise, ack_fall: ack_fall};

  ack_out_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .bsr_stb (bsr_stb),
    .bsr_bit (bsr_bit),
    .obf_n   (per_obf_n),
    .taken   (byte_taken),
    .ie      (ie_q),
    .intr    (intr_req)
  );

  ack_out_drive #(.DATA_W(DATA_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_rise),
    .wdata      (cpu_wdata),
    .shared_bus (bidir_mode),
    .ack_low    (~ack_s),
    .pins       (pin_data),
    .oe         (pin_oe)
  );

endmodule

// File: rtl/ack_out_port_chk.sv
module ack_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              bidir_mode,
  input logic              per_obf_n,
  input logic              intr_req,
  input logic [DATA_W-1:0] pin_data,
  input logic              pin_oe,
  input logic              wr_rise,
  input logic              wr_fall,
  input logic              ack_rise,
  input logic              ack_fall,
  input logic              byte_taken,
  input logic              ie_q
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (per_obf_n && !intr_req));

  assert_write_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> (!per_obf_n && pin_data == $past(cpu_wdata)));

  assert_write_clears_intr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> !intr_req);

  assert_ack_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !wr_rise) |=> per_obf_n);

  assert_intr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_req) |-> $past(ack_rise && byte_taken && ie_q));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && per_obf_n) |=> !byte_taken);

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !intr_req) |=> !intr_req);

  assert_strobed_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bidir_mode |-> pin_oe);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && ack_fall) |=> !per_obf_n);

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> !$rose(intr_req));

endmodule

bind ack_out_port ack_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wdata  (cpu_wdata),
  .bidir_mode (bidir_mode),
  .per_obf_n  (per_obf_n),
  .intr_req   (intr_req),
  .pin_data   (pin_data),
  .pin_oe     (pin_oe),
  .wr_rise    (wr_rise),
  .wr_fall    (wr_fall),
  .ack_rise   (ack_rise),
  .ack_fall   (ack_fall),
  .byte_taken (byte_taken),
  .ie_q       (ie_q)
);

// File: tb/ack_out_port_test.sv
`timescale 1ns/1ps
module ack_out_port_test;

  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr_n = 1'b1;
  logic [DW-1:0] cpu_wdata = '0;
  logic          bsr_stb = 1'b0;
  logic          bsr_bit = 1'b0;
  logic          bidir_mode = 1'b0;
  logic          per_ack_n = 1'b1;
  logic          per_obf_n, intr_req, pin_oe;
  logic [DW-1:0] pin_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ack_out_port #(.DATA_W(DW), .ACK_SYNC(2)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
    .bsr_stb(bsr_stb), .bsr_bit(bsr_bit), .bidir_mode(bidir_mode),
    .per_ack_n(per_ack_n), .per_obf_n(per_obf_n), .intr_req(intr_req),
    .pin_data(pin_data), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk); bsr_stb = 1'b1; bsr_bit = v;
    @(negedge clk); bsr_stb = 1'b0;
  endtask

  // Write pulse: low for one cycle, then high. The sample taken after it
  // sees the rising edge registered.
  task automatic write_byte(input logic [DW-1:0] d, input string req);
    @(negedge clk); cpu_wr_n = 1'b0; cpu_wdata = d;
    @(negedge clk);
    check("R3", {"intr after write start ", req}, intr_req, 0);
    cpu_wr_n = 1'b1;
    @(negedge clk);
  endtask

  // Two sync stages plus the edge register: sample three negedges later.
  task automatic ack_level(input logic v);
    @(negedge clk); per_ack_n = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "obf_n after reset", per_obf_n, 1);
    check("R1", "intr after reset", intr_req, 0);
    check("R1", "pins after reset", pin_data, 0);
    check("R8", "oe strobed after reset", pin_oe, 1);

    // R1 enable is 0, and R6 needs a pending byte: acknowledge with none.
    ack_level(1'b0); ack_level(1'b1);
    check("R1", "enable off, idle ack leaves intr low", intr_req, 0);
    set_enable(1'b1);
    ack_level(1'b0);
    check("R6", "obf_n stays high on idle ack", per_obf_n, 1);
    ack_level(1'b1);
    check("R6", "idle ack with enable=1 no intr", intr_req, 0);

    // Exhaustive sweep: every data value, both modes, both enable values.
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        bidir_mode = m[0];
        set_enable(e[0]);
        for (int d = 0; d < (1 << DW); d++) begin
          write_byte(d[DW-1:0], "sweep");
          check("R2", "obf_n after write", per_obf_n, 0);
          check("R2", "latched data", pin_data, d);
          check(m ? "R9" : "R8", "oe with ack high", pin_oe, m ? 0 : 1);
          ack_level(1'b0);
          check("R4", "obf_n after ack", per_obf_n, 1);
          check(m ? "R9" : "R8", "oe with ack low", pin_oe, 1);
          ack_level(1'b1);
          check(e ? "R5" : "R7", "intr after ack release", intr_req, e);
          check(m ? "R9" : "R8", "oe after release", pin_oe, m ? 0 : 1);
          check("R8", "data kept after ack", pin_data, d);
        end
      end
    end

    // R10: write rising edge and ack falling edge on the same clock edge.
    bidir_mode = 1'b0;
    set_enable(1'b1);
    write_byte(4'h3, "pre");
    @(negedge clk); cpu_wr_n = 1'b0; per_ack_n = 1'b0; cpu_wdata = 4'hA;
    @(negedge clk);
    @(negedge clk); cpu_wr_n = 1'b1;
    @(negedge clk);
    check("R10", "obf_n on coincident edges", per_obf_n, 0);
    check("R10", "new byte latched", pin_data, 4'hA);
    ack_level(1'b1);
    check("R10", "no intr while new byte pending", intr_req, 0);

    // Complete that byte so intr is set, ready for R11.
    ack_level(1'b0); ack_level(1'b1);
    check("R5", "intr after second ack", intr_req, 1);

    // R11: write falling edge and qualifying ack rising edge together.
    write_byte(4'h5, "r11 prep");
    ack_level(1'b0);
    @(negedge clk); per_ack_n = 1'b1;
    @(negedge clk);
    @(negedge clk); cpu_wr_n = 1'b0;
    @(negedge clk);
    check("R11", "clear beats set", intr_req, 0);
    @(negedge clk); cpu_wr_n = 1'b1;
    @(negedge clk);
    check("R11", "intr still low after write", intr_req, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule